// File: doc/BRIEF.md
# Sample-Number Stream Aligner

This block brings two streams of complex 16-bit samples into step. Each incoming frame carries a counter channel first and then one or three data channels. The counter channel holds an unsigned 32-bit sample number, with its upper half in the I word and its lower half in the Q word. The block takes one frame from each stream over a valid/ready handshake and compares the two sample numbers.

While the two numbers differ, the stream whose head is behind (modulo 2^32) has its head discarded and nothing is emitted. Once the numbers match, the two frames leave together as one combined output frame, with their layout unchanged. The block then reports itself locked. If a later pair of heads disagrees, it raises a one-cycle error flag, drops out of lock and goes back to discarding until the numbers meet again.

The frame width is set by the total channel count, which is 2 or 4 and includes the counter channel. A spare alignment-interval parameter is accepted and has no effect on behaviour. The decision is combinational from head to handshake, so a frame can be dropped or forwarded in every cycle.

Top module: `sample_aligner`

## Requirements
- R1: Channel k of a frame occupies bits [32k+31:32k]. Its I word is in bits [32k+31:32k+16] and its Q word in bits [32k+15:32k]. The sample number is channel 0 read as {I, Q}, so I holds the upper 16 bits.
- R2: When both inputs are valid, their sample numbers are equal and out_ready is high, out_valid is high and both a_ready and b_ready are high in the same cycle.
- R3: When both inputs are valid and the sample numbers differ, out_valid is low. Only the stream whose number is behind has its ready high, whatever the state of out_ready.
- R4: "Behind" is judged modulo 2^32: a is behind b when (a - b) mod 2^32 is 2^31 or more. So 0xFFFFFFFF is behind 0x00000002.
- R5: out_a_data and out_b_data equal a_data and b_data bit for bit, with the counter on channel 0 followed by the data channels. out_valid is high only when a combined frame is presented.
- R6: If either input is not valid, both readies and out_valid are low. If the heads match but out_ready is low, out_valid is high and both readies are low.
- R7: locked goes high on the clock edge after the first combined frame is accepted, and stays high while later head pairs match.
- R8: While locked, a cycle in which both inputs are valid with differing numbers clears locked and pulses align_err high for exactly one cycle on the following edge.
- R9: While rst_n is low at a clock edge, locked and align_err are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Stream A head frame present |
| a_ready | output | 1 | Stream A head consumed (forwarded or dropped) |
| a_data | input | NUM_CH*32 | Stream A frame, counter on channel 0 |
| b_valid | input | 1 | Stream B head frame present |
| b_ready | output | 1 | Stream B head consumed (forwarded or dropped) |
| b_data | input | NUM_CH*32 | Stream B frame, counter on channel 0 |
| out_valid | output | 1 | Combined aligned frame presented |
| out_ready | input | 1 | Downstream accepts the combined frame |
| out_a_data | output | NUM_CH*32 | Aligned stream A frame |
| out_b_data | output | NUM_CH*32 | Aligned stream B frame |
| locked | output | 1 | Streams currently aligned |
| align_err | output | 1 | One-cycle pulse on loss of alignment |

## Verification
The hardest situation to reach is a loss of lock that coincides with counter wrap-around. It requires a locked state, then a head pair straddling 0xFFFFFFFF, where the numerically larger value is the one behind. The stimulus table first builds lock from a gap of two samples and then feeds such a straddling pair. In a later row it feeds the opposite case, where B is the stream that wrapped, with out_ready low. This shows that discarding does not wait for downstream and that the error pulse still fires. A further row uses counters whose I and Q halves give opposite orderings depending on which half is taken as upper, so it pins down the counter reconstruction.

// File: rtl/aligner_pkg.sv
// Package: shared widths and the lock state type for the stream aligner.
// Assumes 16-bit I and Q words and a 32-bit sample number.
package aligner_pkg;
    localparam int HALF_W = 16;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int CH_W   = 2 * HALF_W;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/aligner_cnt_extract.sv
// Module: rebuilds the 32-bit sample number from the counter channel.
// Assumes the channel is given as {I, Q}, where I carries the upper half.
module aligner_cnt_extract
    import aligner_pkg::*;
(
    input  logic [CH_W-1:0]  cnt_chan,
    output logic [CNT_W-1:0] sample_num
);
    logic [HALF_W-1:0] i_word;
    logic [HALF_W-1:0] q_word;

    // Split the channel into its I and Q words and join them upper-first.
    always_comb begin
        i_word     = cnt_chan[HALF_W +: HALF_W];
        q_word     = cnt_chan[0 +: HALF_W];
        sample_num = {i_word, q_word};
    end
endmodule

// File: rtl/aligner_compare.sv
// Module: compares two sample numbers modulo 2^CNT_W.
// Assumes the true distance between the heads is below 2^(CNT_W-1).
module aligner_compare #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] num_a,
    input  logic [CNT_W-1:0] num_b,
    output logic             same,
    output logic             a_behind,
    output logic             b_behind
);
    logic [CNT_W-1:0] diff;

    // Wrapping difference; its top bit set means A trails B.
    always_comb begin
        diff     = num_a - num_b;
        same     = (diff == '0);
        a_behind = diff[CNT_W-1];
        b_behind = !same && !diff[CNT_W-1];
    end
endmodule

// File: rtl/aligner_lock_ctrl.sv
// Module: tracks whether the streams are aligned and flags loss of alignment.
// Assumes 'fire' marks an accepted combined frame and 'slip' marks a mismatched head pair.
module aligner_lock_ctrl
    import aligner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic slip,
    output logic locked,
    output logic align_err
);
    lock_state_t state_q;
    lock_state_t state_d;
    logic        err_d;

    // Next-state choice: lock on a forwarded pair, fall back on a slip.
    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        if (state_q == ST_LOCKED && slip) begin
            state_d = ST_SEARCH;
            err_d   = 1'b1;
        end else if (fire) begin
            state_d = ST_LOCKED;
        end
    end

    // State and error pulse registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SEARCH;
            align_err <= 1'b0;
        end else begin
            state_q   <= state_d;
            align_err <= err_d;
        end
    end

    assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/sample_aligner.sv
// Module: aligns two sample-numbered streams by discarding the lagging head.
// Assumes NUM_CH (2 or 4) channels of 32 bits per frame, with the counter on channel 0.
// ALIGN_INTERVAL is accepted for configuration compatibility and does not affect behaviour.
module sample_aligner
    import aligner_pkg::*;
#(
    parameter int NUM_CH         = 2,
    parameter int ALIGN_INTERVAL = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   a_valid,
    output logic                   a_ready,
    input  logic [NUM_CH*CH_W-1:0] a_data,
    input  logic                   b_valid,
    output logic                   b_ready,
    input  logic [NUM_CH*CH_W-1:0] b_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NUM_CH*CH_W-1:0] out_a_data,
    output logic [NUM_CH*CH_W-1:0] out_b_data,
    output logic                   locked,
    output logic                   align_err
);
    localparam int FRAME_W = NUM_CH * CH_W;
    localparam int N_STR   = 2;

    if (NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
        $error("sample_aligner: NUM_CH must be 2 or 4");
    end
    if (ALIGN_INTERVAL < 0) begin : g_bad_interval
        $error("sample_aligner: ALIGN_INTERVAL must not be negative");
    end

    logic [FRAME_W-1:0] frame   [N_STR];
    logic [CNT_W-1:0]   num     [N_STR];
    logic               same;
    logic               a_behind;
    logic               b_behind;
    logic               both_valid;
    logic               fire;
    logic               slip;

    assign frame[0] = a_data;
    assign frame[1] = b_data;

    for (genvar s = 0; s < N_STR; s++) begin : g_extract
        aligner_cnt_extract u_extract (
            .cnt_chan   (frame[s][CH_W-1:0]),
            .sample_num (num[s])
        );
    end

    aligner_compare #(.CNT_W(CNT_W)) u_compare (
        .num_a    (num[0]),
        .num_b    (num[1]),
        .same     (same),
        .a_behind (a_behind),
        .b_behind (b_behind)
    );

    // Handshake decision: forward a matched pair, or drop the trailing head.
    always_comb begin
        both_valid = a_valid && b_valid;
        out_valid  = both_valid && same;
        fire       = out_valid && out_ready;
        slip       = both_valid && !same;
        a_ready    = fire || (both_valid && a_behind);
        b_ready    = fire || (both_valid && b_behind);
    end

    assign out_a_data = a_data;
    assign out_b_data = b_data;

    aligner_lock_ctrl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .slip      (slip),
        .locked    (locked),
        .align_err (align_err)
    );
endmodule

// File: rtl/sample_aligner_chk.sv
// Module: checker for the stream aligner, watching its ports only.
// Assumes the same NUM_CH as the bound instance.
module sample_aligner_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 a_valid,
    input logic                 a_ready,
    input logic [NUM_CH*32-1:0] a_data,
    input logic                 b_valid,
    input logic                 b_ready,
    input logic [NUM_CH*32-1:0] b_data,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NUM_CH*32-1:0] out_a_data,
    input logic [NUM_CH*32-1:0] out_b_data,
    input logic                 locked,
    input logic                 align_err
);
    // A combined frame only appears for two valid heads with equal numbers.
    assert_matched_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (a_valid && b_valid && a_data[31:0] == b_data[31:0]));

    // Differing heads: no output, and exactly one side is consumed.
    assert_drop_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && a_data[31:0] != b_data[31:0])
            |-> (!out_valid && (a_ready != b_ready)));

    // Presented frames carry both inputs unchanged.
    assert_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_a_data == a_data && out_b_data == b_data));

    // Downstream stall on a matched pair consumes nothing.
    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (!a_ready && !b_ready));

    // A missing head consumes nothing.
    assert_missing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_valid && b_valid) |-> (!a_ready && !b_ready && !out_valid));

    // An accepted combined frame leads to lock.
    assert_lock_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> locked);

    // A mismatch while locked drops lock and flags an error.
    assert_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && a_valid && b_valid && a_data[31:0] != b_data[31:0])
            |=> (!locked && align_err));

    // The error pulse never coexists with lock.
    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !locked);
endmodule

bind sample_aligner sample_aligner_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_valid    (a_valid),
    .a_ready    (a_ready),
    .a_data     (a_data),
    .b_valid    (b_valid),
    .b_ready    (b_ready),
    .b_data     (b_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_a_data (out_a_data),
    .out_b_data (out_b_data),
    .locked     (locked),
    .align_err  (align_err)
);

// File: tb/sample_aligner_tb_top.sv
// Bench: walks a stimulus table through the aligner, then directed reset tests.
module sample_aligner_tb_top;
    localparam int NCH = 4;
    localparam int FW  = NCH * 32;

    typedef struct packed {
        logic        av;
        logic        bv;
        logic [31:0] ac;
        logic [31:0] bc;
        logic        ordy;
        logic        ear;
        logic        ebr;
        logic        eov;
        logic        elk;
        logic        eer;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 32'd5,          32'd3,          1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 b behind
        '{1'b1, 1'b1, 32'd5,          32'd4,          1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b1, 1'b1, 32'd5,          32'd5,          1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 stall
        '{1'b1, 1'b1, 32'd5,          32'd5,          1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 R7
        '{1'b1, 1'b1, 32'd6,          32'd6,          1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 stays
        '{1'b0, 1'b1, 32'd7,          32'd7,          1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 a missing
        '{1'b1, 1'b0, 32'd7,          32'd7,          1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 b missing
        '{1'b1, 1'b1, 32'd7,          32'd9,          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 slip
        '{1'b1, 1'b1, 32'd8,          32'd9,          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 one-cycle pulse
        '{1'b1, 1'b1, 32'd9,          32'd9,          1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 relock
        '{1'b1, 1'b1, 32'hFFFF_FFFF,  32'd2,          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 a wrapped behind
        '{1'b1, 1'b1, 32'd2,          32'd2,          1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2
        '{1'b1, 1'b1, 32'd1,          32'hFFFF_FFF0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 b behind, stalled
        '{1'b1, 1'b1, 32'h0000_0002,  32'h0001_0000,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 halves order
        '{1'b1, 1'b1, 32'd70000,      32'd70000,      1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}  // R5 data
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_valid = 1'b0;
    logic          b_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [FW-1:0] a_data = '0;
    logic [FW-1:0] b_data = '0;
    logic          a_ready;
    logic          b_ready;
    logic          out_valid;
    logic [FW-1:0] out_a_data;
    logic [FW-1:0] out_b_data;
    logic          locked;
    logic          align_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    sample_aligner #(.NUM_CH(NCH), .ALIGN_INTERVAL(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_valid    (a_valid),
        .a_ready    (a_ready),
        .a_data     (a_data),
        .b_valid    (b_valid),
        .b_ready    (b_ready),
        .b_data     (b_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_a_data (out_a_data),
        .out_b_data (out_b_data),
        .locked     (locked),
        .align_err  (align_err)
    );

    // Frame per R1: channel 0 = {I=cnt[31:16], Q=cnt[15:0]}, others a pattern.
    function automatic logic [FW-1:0] make_frame(logic [31:0] cnt, int seed);
        logic [FW-1:0] f;
        f[31:0] = {cnt[31:16], cnt[15:0]};
        for (int k = 1; k < NCH; k++) begin
            f[k*32 +: 32] = {16'(seed * 7 + k), 16'(16'hA500 + seed + k * 3)};
        end
        return f;
    endfunction

    task automatic check(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string row_tag(int i, string dflt);
        if (i == 13) return "R1";
        if (i == 10 || i == 12) return "R4";
        if (i == 2 || i == 5 || i == 6) return "R6";
        return dflt;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9 locked after reset", FW'(locked), FW'(0));
        check("R9 align_err after reset", FW'(align_err), FW'(0));
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_valid   = VEC[i].av;
            b_valid   = VEC[i].bv;
            out_ready = VEC[i].ordy;
            a_data    = make_frame(VEC[i].ac, i);
            b_data    = make_frame(VEC[i].bc, i + 40);
            #1;
            check({row_tag(i, "R3"), " a_ready"}, FW'(a_ready), FW'(VEC[i].ear));
            check({row_tag(i, "R3"), " b_ready"}, FW'(b_ready), FW'(VEC[i].ebr));
            check({row_tag(i, "R2"), " out_valid"}, FW'(out_valid), FW'(VEC[i].eov));
            if (VEC[i].eov) begin
                // R5: frames pass through with layout unchanged
                check("R5 out_a_data", out_a_data, make_frame(VEC[i].ac, i));
                check("R5 out_b_data", out_b_data, make_frame(VEC[i].bc, i + 40));
            end
            @(posedge clk);
            #1;
            check("R7 locked", FW'(locked), FW'(VEC[i].elk));
            check("R8 align_err", FW'(align_err), FW'(VEC[i].eer));
        end

        // R9: reset while locked clears the state
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        rst_n   = 1'b0;
        @(posedge clk);
        #1;
        check("R9 locked cleared by reset", FW'(locked), FW'(0));
        check("R9 align_err cleared by reset", FW'(align_err), FW'(0));

        // R8: mismatch while searching gives no error pulse
        @(negedge clk);
        rst_n   = 1'b1;
        a_valid = 1'b1;
        b_valid = 1'b1;
        a_data  = make_frame(32'd100, 1);
        b_data  = make_frame(32'd90, 2);
        @(posedge clk);
        #1;
        check("R8 no error while searching", FW'(align_err), FW'(0));
        check("R7 still searching", FW'(locked), FW'(0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule